// File: doc/BRIEF.md
# Dataway Command Decoder with Monitor Readback

This block sits behind the dataway interface of a digital input/output module. It decodes each addressed command from its function and subaddress codes and answers in the same cycle. Read commands return one of four things on a 16-bit read bus: a word from the monitor cache, a packed status and control word, the cache word at an internal auto-increment pointer, or a fixed module identifier. Write commands load a new pulse flag and control bit pattern into the control register, and a reset command clears that register.

The block drives the cache read address and takes the returned word back combinationally. It reads the control register's current state back, and sends it a write strobe with data and a clear strobe. The clear strobe also follows the synchronous power-up reset and the dataway clear. The attention (LAM) output is raised when the monitor update process is idle or when an external word-0 fault input is high. A supported command answers with Q and X high in the same cycle. Every other code combination answers with both low and changes nothing.

Top module: `dwio_top`

## Requirements
- R1: With the command strobe high, function 0 and subaddress n below NUM_WORDS drive the cache address to n and return the cache word n on the read bus in the same cycle.
- R2: Function 1 with subaddress 0 returns the status word: bit 15 the control register pulse flag, bit 14 LAM, bit 13 update-active, bit 12 zero, bits 11..0 the control bits.
- R3: Function 1 with subaddress 0 sets the auto-increment pointer to 0 at the clock edge that ends the command.
- R4: Function 4 with subaddress 0 returns the cache word at the pointer. The pointer then advances by one at the clock edge, and from NUM_WORDS-1 it goes to 0.
- R5: Function 6 with subaddress 0 returns MODULE_ID, 0x00B4 by default, with all other bits zero.
- R6: The clear strobe to the control register is high in any cycle where reset, the dataway clear input, or a strobed function 9 with subaddress 0 is high.
- R7: Function 17 with subaddress 0 raises the control write strobe in the same cycle, with the pulse flag taken from write bit 15 and the control bits from write bits 11..0. Write bits 14..12 have no effect.
- R8: Every supported command (functions 0, 1, 4, 6, 9 and 17 as above) returns Q=1 and X=1 in the same cycle.
- R9: Any other function, a nonzero subaddress with functions 1, 4, 6, 9 or 17, or function 0 with a subaddress of NUM_WORDS or more returns Q=0, X=0 and a zero read bus. It raises no write or command clear and leaves the pointer unchanged.
- R10: The read bus is zero while the command strobe is low and during write and reset commands.
- R11: LAM is high when update-active is low or the word-0 fault input is high. After reset the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| dw_clear | input | 1 | Dataway clear condition |
| cmd_valid | input | 1 | Module addressed, command strobe |
| func | input | 5 | Function code |
| subaddr | input | 4 | Subaddress |
| wdata | input | 16 | Dataway write lines |
| rdata | output | 16 | Dataway read lines |
| q_resp | output | 1 | Q response |
| x_resp | output | 1 | X response |
| lam | output | 1 | Attention request |
| upd_active | input | 1 | Monitor update process running |
| word0_fault | input | 1 | External fault from monitor word 0 byte check |
| cache_raddr | output | PTR_W | Monitor cache read address |
| cache_rdata | input | 16 | Monitor cache read data |
| ctrl_p | input | 1 | Control register pulse flag readback |
| ctrl_bits | input | 12 | Control register bits readback |
| ctrl_wr | output | 1 | Control register write strobe |
| ctrl_wr_p | output | 1 | Pulse flag to write |
| ctrl_wr_bits | output | 12 | Control bits to write |
| ctrl_clr | output | 1 | Control register clear strobe |

## Verification
The bench builds the block with NUM_WORDS set to 12, not the default 16. With that value, function 0 subaddresses 12 to 15 become unsupported codes that the bench can reach, and the pointer wraps after 12 auto-increment reads instead of 16. The default MODULE_ID is kept, so the identifier read is checked against 0x00B4.

// File: rtl/dwio_pkg.sv
package dwio_pkg;
    localparam int DW = 16;
    localparam int CW = 12;
    localparam int FW = 5;
    localparam int AW = 4;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_RD_WORD,
        OP_RD_STAT,
        OP_RD_AUTO,
        OP_RD_ID,
        OP_RESET,
        OP_WR_CTRL
    } op_e;

    typedef struct packed {
        logic          p;
        logic [CW-1:0] bits;
    } ctrl_t;

    typedef struct packed {
        logic          p;
        logic          lam;
        logic          ua;
        logic          zero;
        logic [CW-1:0] bits;
    } status_t;

    function automatic status_t pack_status(ctrl_t c, logic lam_i, logic ua_i);
        status_t s;
        s.p    = c.p;
        s.lam  = lam_i;
        s.ua   = ua_i;
        s.zero = 1'b0;
        s.bits = c.bits;
        return s;
    endfunction

    function automatic ctrl_t unpack_write(logic [DW-1:0] w);
        ctrl_t c;
        c.p    = w[DW-1];
        c.bits = w[CW-1:0];
        return c;
    endfunction
endpackage

// File: rtl/dwio_decode.sv
module dwio_decode
    import dwio_pkg::*;
#(
    parameter int NUM_WORDS = 16
) (
    input  logic          valid,
    input  logic [FW-1:0] func,
    input  logic [AW-1:0] sub,
    output op_e           op
);
    logic sub_zero;
    assign sub_zero = (sub == '0);

    always_comb begin
        op = OP_NONE;
        if (valid) begin
            unique case (func)
                5'd0:  if (int'(sub) < NUM_WORDS) op = OP_RD_WORD;
                5'd1:  if (sub_zero) op = OP_RD_STAT;
                5'd4:  if (sub_zero) op = OP_RD_AUTO;
                5'd6:  if (sub_zero) op = OP_RD_ID;
                5'd9:  if (sub_zero) op = OP_RESET;
                5'd17: if (sub_zero) op = OP_WR_CTRL;
                default: op = OP_NONE;
            endcase
        end
    end
endmodule

// File: rtl/dwio_rdptr.sv
module dwio_rdptr #(
    parameter int NUM_WORDS = 16,
    parameter int PTR_W     = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             zero,
    input  logic             step,
    output logic [PTR_W-1:0] ptr
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_WORDS - 1);

    always_ff @(posedge clk) begin
        if (rst || zero) begin
            ptr <= '0;
        end else if (step) begin
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end

    // R3: a status read leaves the pointer at zero
    a_r3_ptr_zeroed: assert property (@(posedge clk) disable iff (rst)
        zero |=> (ptr == '0));
    // R4: step advances by one below the last index
    a_r4_ptr_step: assert property (@(posedge clk) disable iff (rst)
        (step && !zero && ptr != LAST) |=> (ptr == $past(ptr) + 1'b1));
    // R4: step wraps at the last index
    a_r4_ptr_wrap: assert property (@(posedge clk) disable iff (rst)
        (step && !zero && ptr == LAST) |=> (ptr == '0));
    // R9: no command, no movement
    a_r9_ptr_hold: assert property (@(posedge clk) disable iff (rst)
        (!step && !zero) |=> $stable(ptr));
endmodule

// File: rtl/dwio_rdmux.sv
module dwio_rdmux
    import dwio_pkg::*;
#(
    parameter logic [7:0] MODULE_ID = 8'hB4
) (
    input  op_e           op,
    input  logic [DW-1:0] cache_word,
    input  status_t       status,
    output logic [DW-1:0] rdata
);
    always_comb begin
        unique case (op)
            OP_RD_WORD, OP_RD_AUTO: rdata = cache_word;
            OP_RD_STAT:             rdata = status;
            OP_RD_ID:               rdata = {{(DW-8){1'b0}}, MODULE_ID};
            default:                rdata = '0;
        endcase
    end
endmodule

// File: rtl/dwio_top.sv
module dwio_top
    import dwio_pkg::*;
#(
    parameter int         NUM_WORDS = 16,
    parameter logic [7:0] MODULE_ID = 8'hB4,
    localparam int        PTR_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dw_clear,
    input  logic             cmd_valid,
    input  logic [4:0]       func,
    input  logic [3:0]       subaddr,
    input  logic [15:0]      wdata,
    output logic [15:0]      rdata,
    output logic             q_resp,
    output logic             x_resp,
    output logic             lam,
    input  logic             upd_active,
    input  logic             word0_fault,
    output logic [PTR_W-1:0] cache_raddr,
    input  logic [15:0]      cache_rdata,
    input  logic             ctrl_p,
    input  logic [11:0]      ctrl_bits,
    output logic             ctrl_wr,
    output logic             ctrl_wr_p,
    output logic [11:0]      ctrl_wr_bits,
    output logic             ctrl_clr
);
    op_e              op;
    logic [PTR_W-1:0] ptr;
    ctrl_t            cur_ctrl;
    ctrl_t            new_ctrl;
    status_t          status;

    dwio_decode #(.NUM_WORDS(NUM_WORDS)) u_decode (
        .valid (cmd_valid),
        .func  (func),
        .sub   (subaddr),
        .op    (op)
    );

    dwio_rdptr #(.NUM_WORDS(NUM_WORDS), .PTR_W(PTR_W)) u_rdptr (
        .clk  (clk),
        .rst  (rst),
        .zero (op == OP_RD_STAT),
        .step (op == OP_RD_AUTO),
        .ptr  (ptr)
    );

    assign lam         = !upd_active || word0_fault;
    assign cur_ctrl    = '{p: ctrl_p, bits: ctrl_bits};
    assign status      = pack_status(cur_ctrl, lam, upd_active);
    assign cache_raddr = (op == OP_RD_AUTO) ? ptr : subaddr[PTR_W-1:0];

    dwio_rdmux #(.MODULE_ID(MODULE_ID)) u_rdmux (
        .op         (op),
        .cache_word (cache_rdata),
        .status     (status),
        .rdata      (rdata)
    );

    assign new_ctrl     = unpack_write(wdata);
    assign ctrl_wr      = (op == OP_WR_CTRL);
    assign ctrl_wr_p    = new_ctrl.p;
    assign ctrl_wr_bits = new_ctrl.bits;
    assign ctrl_clr     = rst || dw_clear || (op == OP_RESET);
    assign q_resp       = (op != OP_NONE);
    assign x_resp       = (op != OP_NONE);

    // R5: identifier read returns the fixed code
    a_r5_id_read: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && func == 5'd6 && subaddr == 4'd0)
            |-> (q_resp && rdata == {8'h00, MODULE_ID}));
    // R6: dataway clear always reaches the control register
    a_r6_clear_path: assert property (@(posedge clk) disable iff (rst)
        dw_clear |-> ctrl_clr);
    // R9: unsupported codes are silent
    a_r9_silent: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !x_resp) |-> (rdata == '0 && !ctrl_wr && !q_resp));
    // R10: idle bus is zero and nothing is written
    a_r10_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |-> (rdata == '0 && !ctrl_wr && !x_resp));
    // R7: write strobe only on its own code
    a_r7_write_code: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |-> (cmd_valid && func == 5'd17 && subaddr == 4'd0));
endmodule

// File: tb/tb_dwio_top.sv
module tb_dwio_top;
    localparam int PERIOD = 10;
    localparam int NW     = 12;

    logic        clk = 1'b0;
    logic        rst, dw_clear, cmd_valid, upd_active, word0_fault, ctrl_p;
    logic [4:0]  func;
    logic [3:0]  subaddr;
    logic [15:0] wdata, rdata, cache_rdata;
    logic [11:0] ctrl_bits, ctrl_wr_bits;
    logic        q_resp, x_resp, lam, ctrl_wr, ctrl_wr_p, ctrl_clr;
    logic [3:0]  cache_raddr;
    logic [15:0] mem [16];
    int          checks = 0;
    int          errors = 0;
    int          ptr_m  = 0;

    always #(PERIOD/2) clk = ~clk;
    assign cache_rdata = mem[cache_raddr];

    dwio_top #(.NUM_WORDS(NW)) dut (
        .clk(clk), .rst(rst), .dw_clear(dw_clear), .cmd_valid(cmd_valid),
        .func(func), .subaddr(subaddr), .wdata(wdata), .rdata(rdata),
        .q_resp(q_resp), .x_resp(x_resp), .lam(lam),
        .upd_active(upd_active), .word0_fault(word0_fault),
        .cache_raddr(cache_raddr), .cache_rdata(cache_rdata),
        .ctrl_p(ctrl_p), .ctrl_bits(ctrl_bits), .ctrl_wr(ctrl_wr),
        .ctrl_wr_p(ctrl_wr_p), .ctrl_wr_bits(ctrl_wr_bits), .ctrl_clr(ctrl_clr)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic issue(logic v, logic [4:0] f, logic [3:0] a, logic [15:0] w,
                         logic clr, string tag);
        logic        eq, ewr, eclr, elam;
        logic [15:0] ed;
        string       tg;
        @(negedge clk);
        cmd_valid   = v;  func = f;  subaddr = a;  wdata = w;  dw_clear = clr;
        upd_active  = 1'($urandom);
        word0_fault = 1'($urandom);
        ctrl_p      = 1'($urandom);
        ctrl_bits   = 12'($urandom);
        #2;
        elam = !upd_active || word0_fault;
        eq = 1'b1; ewr = 1'b0; eclr = clr; ed = 16'h0;
        if (!v) begin eq = 1'b0; tg = "R10"; end
        else if (f == 5'd0 && a < NW) begin ed = mem[a]; tg = "R1"; end
        else if (f == 5'd1 && a == 0) begin
            ed = {ctrl_p, elam, upd_active, 1'b0, ctrl_bits}; tg = "R2";
        end
        else if (f == 5'd4 && a == 0) begin ed = mem[ptr_m]; tg = "R4"; end
        else if (f == 5'd6 && a == 0) begin ed = 16'h00B4; tg = "R5"; end
        else if (f == 5'd9 && a == 0) begin eclr = 1'b1; tg = "R6"; end
        else if (f == 5'd17 && a == 0) begin ewr = 1'b1; tg = "R7"; end
        else begin eq = 1'b0; tg = "R9"; end
        if (tag != "") tg = tag;
        check(eq ? "R8" : (v ? "R9" : "R10"), {30'd0, q_resp, x_resp}, {30'd0, eq, eq});
        check(tg, 32'(rdata), 32'(ed));
        check(ewr ? "R7" : "R9", 32'(ctrl_wr), 32'(ewr));
        if (ewr) check("R7", {19'd0, ctrl_wr_p, ctrl_wr_bits}, {19'd0, w[15], w[11:0]});
        check(eclr ? "R6" : "R9", 32'(ctrl_clr), 32'(eclr));
        check("R11", 32'(lam), 32'(elam));
        @(posedge clk);
        if (v && f == 5'd1 && a == 0) ptr_m = 0;
        else if (v && f == 5'd4 && a == 0) ptr_m = (ptr_m == NW-1) ? 0 : ptr_m + 1;
    endtask

    initial begin
        #(PERIOD*200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1185));
        for (int i = 0; i < 16; i++) mem[i] = 16'($urandom);
        rst = 1'b1; dw_clear = 1'b0; cmd_valid = 1'b0; func = '0; subaddr = '0;
        wdata = '0; upd_active = 1'b1; word0_fault = 1'b0; ctrl_p = 1'b0; ctrl_bits = '0;
        repeat (3) @(negedge clk);
        #2 check("R6", 32'(ctrl_clr), 32'd1);
        @(negedge clk); rst = 1'b0;
        #2 check("R10", 32'(rdata), 32'd0);
        check("R10", {30'd0, q_resp, x_resp}, 32'd0);
        // R11: pointer starts at zero after reset
        issue(1'b1, 5'd4, 4'd0, 16'h0, 1'b0, "R11");
        issue(1'b1, 5'd1, 4'd0, 16'h0, 1'b0, "");
        // R4: full sweep and wrap
        for (int k = 0; k < NW + 2; k++) issue(1'b1, 5'd4, 4'd0, 16'h0, 1'b0, "R4");
        // R3: status read resets the pointer
        issue(1'b1, 5'd1, 4'd0, 16'h0, 1'b0, "R3");
        issue(1'b1, 5'd4, 4'd0, 16'h0, 1'b0, "R3");
        // R9: unsupported subaddress of F4 must not move the pointer
        issue(1'b1, 5'd4, 4'd3, 16'h0, 1'b0, "R9");
        issue(1'b1, 5'd4, 4'd0, 16'h0, 1'b0, "R9");
        for (int n = 0; n < 16; n++) issue(1'b1, 5'd0, 4'(n), 16'h0, 1'b0, "");
        issue(1'b1, 5'd17, 4'd0, 16'hF123, 1'b0, "R7");
        issue(1'b1, 5'd17, 4'd0, 16'h7FFF, 1'b0, "R7");
        issue(1'b1, 5'd17, 4'd2, 16'hFFFF, 1'b0, "R9");
        issue(1'b1, 5'd9, 4'd0, 16'h0, 1'b0, "");
        issue(1'b1, 5'd9, 4'd1, 16'h0, 1'b0, "");
        issue(1'b0, 5'd6, 4'd0, 16'h0, 1'b1, "");
        issue(1'b1, 5'd6, 4'd0, 16'h0, 1'b0, "R5");
        issue(1'b1, 5'd6, 4'd8, 16'h0, 1'b0, "");
        issue(1'b0, 5'd0, 4'd1, 16'h0, 1'b0, "R10");
        for (int r = 0; r < 600; r++) begin
            logic [4:0] f;
            logic [3:0] a;
            case ($urandom % 8)
                0: f = 5'd0;  1: f = 5'd1;  2, 3: f = 5'd4;  4: f = 5'd6;
                5: f = 5'd9;  6: f = 5'd17; default: f = 5'($urandom);
            endcase
            a = (f == 5'd0 || ($urandom % 5) == 0) ? 4'($urandom) : 4'd0;
            issue(($urandom % 8) != 0, f, a, 16'($urandom), ($urandom % 10) == 0, "");
        end
        @(negedge clk); cmd_valid = 1'b0; dw_clear = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule